// File: doc/BRIEF.md
# Two-Level I/O Port Address Decoder

This block turns the 8-bit I/O port address of a small CPU into active-low select lines for the peripherals. A coarse stage looks at the upper nibble of the address and drives one of sixteen block selects, each covering 16 consecutive ports. It does this only while the active-low I/O request is asserted. A fine stage is enabled only by the coarse select of the top block (F0h–FFh). It splits that block into four groups of four ports, using address bits 3–2.

In the top block, group 0 (F0h–F3h) and group 1 (F4h–F7h) are reserved. Group 2 (F8h–FBh) selects a dual-channel serial controller, and group 3 (FCh–FFh) selects the memory bank register. Address bits 1–0 go to the serial controller as its control/data select and its channel select. The low nibble is also exported, so that off-board logic on the expansion bus can decode further inside any block.

Every output is registered once on the rising clock, so the selects are free of glitches and change one cycle after the address and request. The decode is complete: every port has exactly one block, and no block answers at any other address.

Top module: `io_port_decoder`

## Requirements
- R1: While rst_ni is low, every bit of blk_sel_no and grp_sel_no is 1 (inactive), and ser_cd_o, ser_ba_o and exp_addr_o are 0.
- R2: One clock edge after inputs are sampled with iorq_ni = 0, blk_sel_no[n] is 0 exactly when port_addr_i[7:4] equals n, and is 1 otherwise.
- R3: One clock edge after a sample with iorq_ni = 1, all sixteen blk_sel_no bits are 1, whatever the address.
- R4: After any sample with iorq_ni = 0, exactly one blk_sel_no bit is 0, so each port address maps to one block with no mirroring.
- R5: grp_sel_no[k] is 0 only if the sample had iorq_ni = 0, port_addr_i[7:4] = 4'hF and port_addr_i[3:2] = k. At most one grp_sel_no bit is 0, and only while blk_sel_no[15] is 0.
- R6: Ports F0h–F3h select group 0 and F4h–F7h select group 1 (both reserved). Ports F8h–FBh select group 2 (serial controller), and ports FCh–FFh select group 3 (bank register).
- R7: One edge after a sample, ser_cd_o equals port_addr_i[0] (1 = control, 0 = data) and ser_ba_o equals port_addr_i[1] (1 = channel B, 0 = channel A). This gives F8h = A data, F9h = A control, FAh = B data and FBh = B control.
- R8: One edge after a sample, exp_addr_o equals port_addr_i[3:0], independent of iorq_ni.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| port_addr_i | input | 8 | CPU I/O port address |
| iorq_ni | input | 1 | Active-low I/O request |
| blk_sel_no | output | 16 | Active-low coarse selects, one per 16-port block |
| grp_sel_no | output | 4 | Active-low fine selects within block F0h–FFh |
| ser_cd_o | output | 1 | Serial controller control/data select (address bit 0) |
| ser_ba_o | output | 1 | Serial controller channel select (address bit 1) |
| exp_addr_o | output | 4 | Low address nibble for expansion-bus decoding |

## Verification
Because of the output register, a bad decode appears at the ports one clock after the offending address: a missing, doubled or wrong block select. The same applies to a group select that is active outside F0h–FFh or without its coarse block. A fine enable taken from the wrong coarse line would make a group select answer at a mirrored block. This can only be seen when the address steps through each block, so every upper nibble is swept with the request both asserted and released. A stale register would show as outputs that lag the inputs by an extra cycle, so each vector is sampled exactly one edge after it is applied.

// File: rtl/io_dec_pkg.sv
package io_dec_pkg;
  localparam int ADDR_W   = 8;
  localparam int BLK_BITS = 4;
  localparam int GRP_BITS = 2;
  localparam int NUM_BLK  = 1 << BLK_BITS;
  localparam int NUM_GRP  = 1 << GRP_BITS;
  localparam int BLK_LSB  = ADDR_W - BLK_BITS;
  localparam int GRP_LSB  = BLK_LSB - GRP_BITS;
  localparam int TOP_BLK  = NUM_BLK - 1;
  localparam int GRP_SERIAL = 2;
  localparam int GRP_BANK   = 3;
endpackage

// File: rtl/io_sel_decoder.sv
module io_sel_decoder #(
  parameter int IN_W = 4,
  localparam int OUT_N = 1 << IN_W
) (
  input  logic            en_i,
  input  logic [IN_W-1:0] code_i,
  output logic [OUT_N-1:0] sel_no
);
  for (genvar i = 0; i < OUT_N; i++) begin : g_sel
    assign sel_no[i] = ~(en_i && (code_i == IN_W'(i)));
  end

  always_comb begin
    if (!en_i) assert (&sel_no) else $error("decoder active while disabled");
  end
endmodule

// File: rtl/io_port_decoder.sv
module io_port_decoder
  import io_dec_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [ADDR_W-1:0]  port_addr_i,
  input  logic               iorq_ni,
  output logic [NUM_BLK-1:0] blk_sel_no,
  output logic [NUM_GRP-1:0] grp_sel_no,
  output logic               ser_cd_o,
  output logic               ser_ba_o,
  output logic [BLK_LSB-1:0] exp_addr_o
);
  logic [NUM_BLK-1:0] blk_d;
  logic [NUM_GRP-1:0] grp_d;

  io_sel_decoder #(.IN_W(BLK_BITS)) u_coarse (
    .en_i   (~iorq_ni),
    .code_i (port_addr_i[ADDR_W-1:BLK_LSB]),
    .sel_no (blk_d)
  );

  // fine stage hangs off the top coarse select, not a separate compare
  io_sel_decoder #(.IN_W(GRP_BITS)) u_fine (
    .en_i   (~blk_d[TOP_BLK]),
    .code_i (port_addr_i[BLK_LSB-1:GRP_LSB]),
    .sel_no (grp_d)
  );

  if (REG_OUT) begin : g_reg
    logic live_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        blk_sel_no <= '1;
        grp_sel_no <= '1;
        ser_cd_o   <= 1'b0;
        ser_ba_o   <= 1'b0;
        exp_addr_o <= '0;
        live_q     <= 1'b0;
      end else begin
        blk_sel_no <= blk_d;
        grp_sel_no <= grp_d;
        ser_cd_o   <= port_addr_i[0];
        ser_ba_o   <= port_addr_i[1];
        exp_addr_o <= port_addr_i[BLK_LSB-1:0];
        live_q     <= 1'b1;
      end
    end

    p_idle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni || !live_q)
      $past(iorq_ni) |-> (&blk_sel_no));
    p_one_blk_r4: assert property (@(posedge clk_i) disable iff (!rst_ni || !live_q)
      !$past(iorq_ni) |-> ($countones(~blk_sel_no) == 1));
    p_grp_onehot_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(~grp_sel_no));
    p_grp_gate_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (~grp_sel_no != '0) |-> !blk_sel_no[TOP_BLK]);
    p_ser_cd_r7: assert property (@(posedge clk_i) disable iff (!rst_ni || !live_q)
      ser_cd_o == $past(port_addr_i[0]));
    p_exp_r8: assert property (@(posedge clk_i) disable iff (!rst_ni || !live_q)
      exp_addr_o == $past(port_addr_i[BLK_LSB-1:0]));
  end else begin : g_comb
    assign blk_sel_no = rst_ni ? blk_d : '1;
    assign grp_sel_no = rst_ni ? grp_d : '1;
    assign ser_cd_o   = rst_ni & port_addr_i[0];
    assign ser_ba_o   = rst_ni & port_addr_i[1];
    assign exp_addr_o = rst_ni ? port_addr_i[BLK_LSB-1:0] : '0;
  end
endmodule

// File: tb/tb_io_port_decoder.sv
module tb_io_port_decoder;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  port_addr_i = 8'h00;
  logic        iorq_ni = 1'b1;
  logic [15:0] blk_sel_no;
  logic [3:0]  grp_sel_no;
  logic        ser_cd_o, ser_ba_o;
  logic [3:0]  exp_addr_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  io_port_decoder dut (
    .clk_i, .rst_ni, .port_addr_i, .iorq_ni,
    .blk_sel_no, .grp_sel_no, .ser_cd_o, .ser_ba_o, .exp_addr_o
  );

  // {iorq_n, addr, expected block (16 = none), expected group (4 = none)}
  localparam int NV = 14;
  localparam logic [16:0] VEC [NV] = '{
    {1'b0, 8'h00, 5'd0,  3'd4},
    {1'b0, 8'h1F, 5'd1,  3'd4},
    {1'b0, 8'h5A, 5'd5,  3'd4},
    {1'b0, 8'hCF, 5'd12, 3'd4},
    {1'b0, 8'hD0, 5'd13, 3'd4},
    {1'b0, 8'hEF, 5'd14, 3'd4},
    {1'b0, 8'hF0, 5'd15, 3'd0},
    {1'b0, 8'hF7, 5'd15, 3'd1},
    {1'b0, 8'hF8, 5'd15, 3'd2},
    {1'b0, 8'hFB, 5'd15, 3'd2},
    {1'b0, 8'hFC, 5'd15, 3'd3},
    {1'b0, 8'hFF, 5'd15, 3'd3},
    {1'b1, 8'hFF, 5'd16, 3'd4},
    {1'b1, 8'h00, 5'd16, 3'd4}
  };

  function automatic logic [15:0] blk_exp(int b);
    return (b >= 16) ? 16'hFFFF : ~(16'h1 << b);
  endfunction
  function automatic logic [3:0] grp_exp(int g);
    return (g >= 4) ? 4'hF : ~(4'h1 << g);
  endfunction

  task automatic check(bit ok, string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(logic iorq_n, logic [7:0] a);
    @(negedge clk_i);
    iorq_ni = iorq_n;
    port_addr_i = a;
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 20);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    #35;
    // R1 reset state
    check(blk_sel_no == 16'hFFFF, "R1 blk", blk_sel_no, 16'hFFFF);
    check(grp_sel_no == 4'hF, "R1 grp", 16'(grp_sel_no), 16'hF);
    check({ser_cd_o, ser_ba_o, exp_addr_o} == 6'd0, "R1 ser/exp",
          16'({ser_cd_o, ser_ba_o, exp_addr_o}), 16'h0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    // vector table: R2 R3 R5 R6 R7 R8
    for (int i = 0; i < NV; i++) begin
      logic [7:0] a;
      logic [15:0] eb;
      logic [3:0] eg;
      a  = VEC[i][15:8];
      eb = blk_exp(int'(VEC[i][7:3]));
      eg = grp_exp(int'(VEC[i][2:0]));
      apply(VEC[i][16], a);
      check(blk_sel_no == eb, VEC[i][16] ? "R3 blk idle" : "R2 blk", blk_sel_no, eb);
      check(grp_sel_no == eg, "R6 grp", 16'(grp_sel_no), 16'(eg));
      check({ser_ba_o, ser_cd_o} == a[1:0], "R7 ser", 16'({ser_ba_o, ser_cd_o}), 16'(a[1:0]));
      check(exp_addr_o == a[3:0], "R8 exp", 16'(exp_addr_o), 16'(a[3:0]));
    end

    // exhaustive sweep: R4 R5 and gating
    for (int r = 0; r < 2; r++) begin
      for (int v = 0; v < 256; v++) begin
        logic [15:0] eb;
        logic [3:0] eg;
        apply(r[0], v[7:0]);
        eb = (r == 1) ? 16'hFFFF : ~(16'h1 << v[7:4]);
        eg = (r == 0 && v[7:4] == 4'hF) ? ~(4'h1 << v[3:2]) : 4'hF;
        check(blk_sel_no == eb, r ? "R3 sweep" : "R4 sweep", blk_sel_no, eb);
        check(grp_sel_no == eg, "R5 sweep", 16'(grp_sel_no), 16'(eg));
      end
    end

    // latency: output holds previous sample until the edge
    apply(1'b0, 8'h30);
    @(negedge clk_i);
    port_addr_i = 8'h40;
    #2;
    check(blk_sel_no == ~16'h0008, "R2 latency", blk_sel_no, ~16'h0008);
    @(posedge clk_i);
    @(negedge clk_i);
    check(blk_sel_no == ~16'h0010, "R2 next", blk_sel_no, ~16'h0010);

    // async reset mid-run
    apply(1'b0, 8'hFA);
    #3 rst_ni = 1'b0;
    #2;
    check(blk_sel_no == 16'hFFFF, "R1 async blk", blk_sel_no, 16'hFFFF);
    check(grp_sel_no == 4'hF, "R1 async grp", 16'(grp_sel_no), 16'hF);
    check({ser_cd_o, ser_ba_o, exp_addr_o} == 6'd0, "R1 async ser",
          16'({ser_cd_o, ser_ba_o, exp_addr_o}), 16'h0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    apply(1'b0, 8'hFA);
    check(grp_sel_no == 4'b1011, "R6 serial after reset", 16'(grp_sel_no), 16'hB);
    check({ser_ba_o, ser_cd_o} == 2'b10, "R7 channel B data", 16'({ser_ba_o, ser_cd_o}), 16'h2);

    finish_run();
  end
endmodule